// File: doc/BRIEF.md
# Pause-Width Bit Frame Transmitter

This block sends a frame from a reader to a card by switching the carrier off for short pauses. A shared free-running tick counter runs at 1.5 ticks per microsecond and drives all timing. A start request brings in a frame word, a bit count and the timestamp at which the previous frame on air ended. The block waits a fixed gap after that timestamp. It then sends each bit as a fixed carrier-off pause followed by carrier-on time. The full period of the bit carries its value.

Each data bit is XORed with one bit from an external keystream generator. The block pulses an advance strobe to that generator once per bit. When the last bit is done, one more pause closes the frame. The block then reports the scheduled end time of the frame, and the caller can pass that time straight back as the reference for the next frame. Every deadline is the previous deadline plus a fixed interval. The block never uses the moment it noticed a deadline, so lateness does not add up from one interval to the next.

Top module: `pwt_frame_tx`

## Requirements
- R1: After reset, `mod_out`, `busy`, `done` and `ks_advance` are all low.
- R2: The first pause of a frame starts 330 ticks after `last_end_i`. Every edge of `mod_out` shows up one clock after the tick count reaches its scheduled instant.
- R3: Every bit starts with a pause of 30 ticks, during which `mod_out` is high (carrier off). Outside pauses `mod_out` is low (carrier on).
- R4: The period of a bit, from the start of its pause to the start of the next pause, is 150 ticks when the sent value is 1 and 90 ticks when it is 0.
- R5: Bit index 0 of `frame_word` goes first and index len-1 goes last. The sent value is `frame_word[i]` XOR `ks_bit`, with `ks_bit` sampled as the pause of bit i ends.
- R6: `ks_advance` is a one-cycle pulse, issued once per bit in the clock in which that bit's pause ends. A frame of n bits gives exactly n pulses.
- R7: A closing pause of 30 ticks follows the last bit. `done` pulses for one cycle as that pause ends. `last_end_o` then holds `last_end_i` + 330 + (sum of bit periods) + 30, modulo 2^TS_W.
- R8: `busy` is high from the clock after an accepted start until the closing pause ends. A start seen while `busy` is high has no effect on the running frame.
- R9: A length of 0 sends only the closing pause. Lengths above 23 are sent as 23 bits.
- R10: Deadlines are compared modulo 2^TS_W, so frames may cross the counter wrap. A deadline that has already passed fires one clock after it is checked. Later deadlines stay on the original schedule.
- R11: A start in the same cycle as `done` is accepted, so frames can run back to back with `last_end_i` taken from `last_end_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_ticks | input | TS_W | Shared free-running tick count |
| start | input | 1 | Frame request, accepted when idle |
| frame_word | input | MAX_BITS | Data bits, index 0 sent first |
| frame_len | input | LEN_W | Number of bits to send |
| last_end_i | input | TS_W | End time of the previous frame on air |
| ks_bit | input | 1 | Current keystream bit |
| ks_advance | output | 1 | One-cycle step strobe to the keystream generator |
| mod_out | output | 1 | High = carrier off (pause), low = carrier on |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of the closing pause |
| last_end_o | output | TS_W | Scheduled end time of the frame, valid from `done` on |

## Verification
Two events can land in the same clock: the end of one frame, signalled by `done`, and the start request for the next. The bench provokes this by raising `start` in the very sample where `done` is seen, with `last_end_i` fed from `last_end_o`. It then judges the result by whether the new frame's first pause lands exactly 330 ticks after the reported end. A second overlap is a start request in the middle of a running frame. The bench judges that one by checking that every bit period, the pulse count and the final timestamp of the running frame still match values worked out from the word and the keystream seed.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [2:0] {
        PW_IDLE,
        PW_GAP,
        PW_PAUSE,
        PW_CARRIER,
        PW_TAIL
    } pw_state_e;

endpackage

// File: rtl/pwt_sched.sv
// Deadline unit: wrap-safe "deadline reached" test and the next deadline.
module pwt_sched #(
    parameter int TS_W = 16
) (
    input  logic [TS_W-1:0] now_ticks,
    input  logic [TS_W-1:0] deadline_q,
    input  logic [TS_W-1:0] step,
    output logic            due,
    output logic [TS_W-1:0] deadline_next
);
    logic [TS_W-1:0] lag;

    always_comb begin
        lag           = now_ticks - deadline_q;
        due           = ~lag[TS_W-1];
        deadline_next = deadline_q + step;
    end
endmodule

// File: rtl/pwt_bitsel.sv
// Picks the current data bit and whitens it with the keystream.
module pwt_bitsel #(
    parameter int MAX_BITS = 23,
    parameter int IDX_W    = 5
) (
    input  logic [MAX_BITS-1:0] word,
    input  logic [IDX_W-1:0]    idx,
    input  logic                ks_bit,
    output logic                chip
);
    logic [MAX_BITS-1:0] shifted;

    always_comb begin
        shifted = word >> idx;
        chip    = shifted[0] ^ ks_bit;
    end
endmodule

// File: rtl/pwt_frame_tx.sv
module pwt_frame_tx #(
    parameter int TS_W     = 16,
    parameter int LEN_W    = 5,
    parameter int MAX_BITS = 23,
    parameter int PAUSE_T  = 30,
    parameter int ONE_T    = 150,
    parameter int ZERO_T   = 90,
    parameter int GAP_T    = 330
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TS_W-1:0]     now_ticks,
    input  logic                start,
    input  logic [MAX_BITS-1:0] frame_word,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic [TS_W-1:0]     last_end_i,
    input  logic                ks_bit,
    output logic                ks_advance,
    output logic                mod_out,
    output logic                busy,
    output logic                done,
    output logic [TS_W-1:0]     last_end_o
);
    import pwt_pkg::*;

    localparam logic [TS_W-1:0]  STEP_PAUSE = TS_W'(PAUSE_T);
    localparam logic [TS_W-1:0]  STEP_ONE   = TS_W'(ONE_T - PAUSE_T);
    localparam logic [TS_W-1:0]  STEP_ZERO  = TS_W'(ZERO_T - PAUSE_T);
    localparam logic [TS_W-1:0]  STEP_GAP   = TS_W'(GAP_T);
    localparam logic [LEN_W-1:0] LEN_CAP    = LEN_W'(MAX_BITS);

    typedef struct packed {
        pw_state_e           st;
        logic [MAX_BITS-1:0] word;
        logic [LEN_W-1:0]    len;
        logic [LEN_W-1:0]    idx;
        logic [TS_W-1:0]     dl;
        logic                mod;
        logic                adv;
        logic                done;
    } regs_t;

    regs_t r_d, r_q;

    logic             due;
    logic             chip;
    logic [TS_W-1:0]  step;
    logic [TS_W-1:0]  dl_next;
    logic [LEN_W-1:0] idx_inc;

    pwt_sched #(.TS_W(TS_W)) u_sched (
        .now_ticks    (now_ticks),
        .deadline_q   (r_q.dl),
        .step         (step),
        .due          (due),
        .deadline_next(dl_next)
    );

    pwt_bitsel #(.MAX_BITS(MAX_BITS), .IDX_W(LEN_W)) u_bitsel (
        .word  (r_q.word),
        .idx   (r_q.idx),
        .ks_bit(ks_bit),
        .chip  (chip)
    );

    always_comb begin
        idx_inc = r_q.idx + 1'b1;
        if (r_q.st == PW_PAUSE) begin
            step = chip ? STEP_ONE : STEP_ZERO;
        end else begin
            step = STEP_PAUSE;
        end

        r_d      = r_q;
        r_d.adv  = 1'b0;
        r_d.done = 1'b0;

        unique case (r_q.st)
            PW_IDLE: begin
                if (start) begin
                    r_d.word = frame_word;
                    r_d.len  = (frame_len > LEN_CAP) ? LEN_CAP : frame_len;
                    r_d.idx  = '0;
                    r_d.dl   = last_end_i + STEP_GAP;
                    r_d.st   = PW_GAP;
                end
            end
            PW_GAP: begin
                if (due) begin
                    r_d.mod = 1'b1;
                    r_d.dl  = dl_next;
                    r_d.st  = (r_q.len == '0) ? PW_TAIL : PW_PAUSE;
                end
            end
            PW_PAUSE: begin
                if (due) begin
                    r_d.mod = 1'b0;
                    r_d.adv = 1'b1;
                    r_d.dl  = dl_next;
                    r_d.st  = PW_CARRIER;
                end
            end
            PW_CARRIER: begin
                if (due) begin
                    r_d.mod = 1'b1;
                    r_d.dl  = dl_next;
                    r_d.idx = idx_inc;
                    r_d.st  = (idx_inc == r_q.len) ? PW_TAIL : PW_PAUSE;
                end
            end
            PW_TAIL: begin
                if (due) begin
                    r_d.mod  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = PW_IDLE;
                end
            end
            default: r_d.st = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: PW_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mod_out    = r_q.mod;
    assign busy       = (r_q.st != PW_IDLE);
    assign done       = r_q.done;
    assign ks_advance = r_q.adv;
    assign last_end_o = r_q.dl;

endmodule

// File: rtl/pwt_frame_tx_chk.sv
module pwt_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic mod_out,
    input logic busy,
    input logic done,
    input logic ks_advance
);
    assert_pause_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mod_out |-> busy);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mod_out));

    assert_adv_on_carrier_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ks_advance |-> (busy && !mod_out));

    assert_adv_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ks_advance |=> !ks_advance);

    assert_busy_ends_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

bind pwt_frame_tx pwt_frame_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mod_out   (mod_out),
    .busy      (busy),
    .done      (done),
    .ks_advance(ks_advance)
);

// File: tb/sim_pwt_frame_tx.sv
module sim_pwt_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] now_t = 16'hF000;   // wraps early in the run (R10)
    logic        start = 1'b0;
    logic [22:0] frame_word = '0;
    logic [4:0]  frame_len = '0;
    logic [15:0] last_end_i = '0;
    logic [7:0]  ks_st = 8'h5B;
    logic [7:0]  ks_seed = 8'h5B;
    logic        ks_bit;
    logic        ks_advance, mod_out, busy, done;
    logic [15:0] last_end_o;
    logic [15:0] edges [0:63];
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;
    always @(posedge clk) now_t <= now_t + 16'd1;

    function automatic logic [7:0] ks_nx(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    assign ks_bit = ks_st[0];
    always @(posedge clk) if (ks_advance) ks_st <= ks_nx(ks_st);

    pwt_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .now_ticks(now_t), .start(start),
        .frame_word(frame_word), .frame_len(frame_len), .last_end_i(last_end_i),
        .ks_bit(ks_bit), .ks_advance(ks_advance), .mod_out(mod_out),
        .busy(busy), .done(done), .last_end_o(last_end_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; start is held for one clock
    task automatic launch(input logic [22:0] w, input logic [4:0] n, input logic [15:0] ts);
        ks_seed    = ks_st;
        frame_word = w;
        frame_len  = n;
        last_end_i = ts;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic observe(input logic [22:0] w, input int len_in, input logic [15:0] ts,
                           input bit late, input logic [15:0] n0, input bit poke, input bit b2b);
        int          n = (len_in > 23) ? 23 : len_in;
        int          ne = 0;
        int          nadv = 0;
        int          advbad = 0;
        int          cyc = 0;
        logic        prev = 1'b0;
        logic        fell;
        logic [7:0]  s = ks_seed;
        logic [15:0] total = '0;
        logic [15:0] last_edge_t = '0;
        bit          b;
        int          dur;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 100) begin
                start = 1'b1; frame_word = ~w; frame_len = 5'd3; last_end_i = now_t;
            end else if (poke && cyc == 101) begin
                start = 1'b0;
            end
            fell = 1'b0;
            if (mod_out != prev) begin
                if (ne < 64) edges[ne] = now_t;
                ne++;
                fell = prev;
                prev = mod_out;
                last_edge_t = now_t;
            end
            if (ks_advance) begin
                nadv++;
                if (!fell) advbad++;
            end
            if (done) break;
            if (cyc > 6000) begin
                chk(0, "R8 frame never ended", cyc, 6000);
                return;
            end
        end
        chk(ne == 2 * n + 2, (len_in == 0 || len_in > 23) ? "R9 edge count" : "R3 edge count", ne, 2 * n + 2);
        if (ne != 2 * n + 2) return;
        for (int i = 0; i < n; i++) begin
            b   = w[i] ^ s[0];
            dur = b ? 150 : 90;
            if (!(late && i == 0)) begin
                chk(16'(edges[2*i+1] - edges[2*i]) == 16'd30, "R3 pause width",
                    int'(16'(edges[2*i+1] - edges[2*i])), 30);
                chk(16'(edges[2*i+2] - edges[2*i]) == 16'(dur), "R4 R5 bit period",
                    int'(16'(edges[2*i+2] - edges[2*i])), dur);
            end
            total = total + 16'(dur);
            s = ks_nx(s);
        end
        chk(16'(edges[2*n+1] - edges[2*n]) == 16'd30, "R7 closing pause",
            int'(16'(edges[2*n+1] - edges[2*n])), 30);
        if (late) begin
            chk(edges[0] == 16'(n0 + 16'd2) && edges[1] == 16'(n0 + 16'd3), "R10 late first pause",
                int'(edges[0]), int'(16'(n0 + 16'd2)));
        end else begin
            chk(edges[0] == 16'(ts + 16'd331), b2b ? "R11 back-to-back start" : "R2 first pause",
                int'(edges[0]), int'(16'(ts + 16'd331)));
        end
        chk(last_end_o == 16'(ts + 16'd360 + total), "R7 end timestamp",
            int'(last_end_o), int'(16'(ts + 16'd360 + total)));
        chk(last_edge_t == now_t, "R7 done with last edge", int'(last_edge_t), int'(now_t));
        chk(nadv == n && advbad == 0, "R6 advance pulses", nadv, n);
        chk(busy == 1'b0, "R8 busy after done", int'(busy), 0);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        logic [22:0] w;
        logic [15:0] n0;
        repeat (3) @(negedge clk);
        chk(!mod_out && !busy && !done && !ks_advance, "R1 reset state",
            int'({mod_out, busy, done, ks_advance}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mod_out && !busy && !done && !ks_advance, "R1 after release",
            int'({mod_out, busy, done, ks_advance}), 0);

        // sweep every legal length; every third frame starts in the done cycle (R11)
        for (int len = 0; len <= 23; len++) begin
            w = 23'(32'h02C5A3B1 * (len + 3));
            if (len % 3 == 2) begin
                launch(w, 5'(len), last_end_o);
                observe(w, len, last_end_i, 1'b0, '0, 1'b0, 1'b1);
            end else begin
                repeat (7) @(negedge clk);
                launch(w, 5'(len), now_t);
                observe(w, len, last_end_i, 1'b0, '0, (len == 9), 1'b0);
            end
        end

        // lengths above the cap (R9)
        repeat (5) @(negedge clk);
        launch(23'h7FFFFF, 5'd24, now_t);
        observe(23'h7FFFFF, 24, last_end_i, 1'b0, '0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        launch(23'h155555, 5'd31, now_t);
        observe(23'h155555, 31, last_end_i, 1'b0, '0, 1'b0, 1'b0);

        // reference already in the past (R10)
        repeat (5) @(negedge clk);
        n0 = now_t;
        launch(23'h00001B, 5'd5, 16'(n0 - 16'd400));
        observe(23'h00001B, 5, last_end_i, 1'b1, n0, 1'b0, 1'b0);

        // idle stays idle without start (R8)
        repeat (20) @(negedge clk);
        chk(!busy && !mod_out && !ks_advance, "R8 idle hold",
            int'({busy, mod_out, ks_advance}), 0);

        finish_run();
    end
endmodule